// File: doc/BRIEF.md
# Segmented Receive Packet Length Tally

This block watches a segmented receive bus of four 128-bit segments and produces one completion record for every packet that ends on it. Packets from up to sixteen logical channels arrive interleaved. Each enabled segment names the channel it belongs to. The block keeps a running byte count for every channel. When a segment closes a packet, the block reports the channel, the total byte length, the error flag and the first payload byte of that packet.

The bus cannot be stalled, so the block accepts every segment in the cycle it appears. Several segments in one cycle can belong to the same channel. They can also start and finish several packets, so the per-segment arithmetic is chained in bus order within the cycle. Each segment slot has its own record output, and no completion is ever merged or dropped. Payload is not stored. Only the top byte of a start segment is kept.

Top module: `seg_len_tally`

## Requirements
- R1: One clock after a cycle in which segment m is enabled (`in_vld[m]`=1) with its end flag set, `rec_vld[m]` is 1. In every other case `rec_vld[m]` is 0.
- R2: An enabled segment whose end flag is clear adds exactly 16 bytes to its channel's running length.
- R3: An enabled end segment adds 16 minus its empty count, `in_empty[4m+3:4m]` (0 to 15), to the length. The invalid lanes are the low-order bytes. A segment that both starts and ends a packet gives a length of 16 minus its empty count.
- R4: An enabled start segment discards the channel's previous running length before adding its own bytes.
- R5: Segments are ordered 0 (earliest) to 3 (latest). Segments of the same channel in one cycle accumulate in that order, so one packet can span several segments of a cycle. One channel can also complete up to four packets in a cycle.
- R6: Each of the 16 channels keeps its own length and first byte. Traffic on one channel never changes another channel's record.
- R7: `rec_err[m]` carries the error bit `in_err[m]` of the end segment that produced the record.
- R8: `rec_first[8m+7:8m]` is bits [127:120] of the data of the packet's start segment, taken from `in_data[128m+127:128m+120]`.
- R9: A segment with `in_vld[m]`=0 has no effect: no record, and no change to any running length or first byte.
- R10: While reset is asserted, and until the first enabled cycle after it, `rec_vld` is 0. All running lengths start at 0 after reset.
- R11: `rec_chan[4m+3:4m]` is the channel number of the end segment that produced the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 4 | Segment enable, one bit per segment |
| in_sop | input | 4 | Segment starts a packet |
| in_eop | input | 4 | Segment ends a packet |
| in_err | input | 4 | Packet ending on the segment is errored |
| in_chan | input | 16 | Channel number, 4 bits per segment |
| in_empty | input | 16 | Invalid byte count of an end segment, 4 bits per segment |
| in_data | input | 512 | Segment data, 128 bits per segment, first byte in the top bits |
| rec_vld | output | 4 | Completion record valid, one per segment slot |
| rec_chan | output | 16 | Channel of each record |
| rec_len | output | 64 | Byte length of each record, 16 bits per slot |
| rec_err | output | 4 | Error flag of each record |
| rec_first | output | 32 | First byte of each record's packet, 8 bits per slot |

## Verification
A wrong running length does not show until that channel's packet ends. It then appears as a bad `rec_len` one cycle after the end segment. The error can sit hidden for several cycles while the packet keeps growing, so the bench generates packets that span many cycles and share channels heavily. A wrong ordering of same-channel segments within a cycle shows at once, in the records of that same cycle. A leak between channels appears as a wrong length or first byte on the next packet of the damaged channel.

// File: rtl/slt_pkg.sv
package slt_pkg;
  parameter int SEG_N     = 4;
  parameter int SEG_BYTES = 16;
  parameter int CHAN_N    = 16;
  parameter int LEN_W     = 16;
  localparam int SEG_W    = SEG_BYTES * 8;
  localparam int CHAN_W   = $clog2(CHAN_N);
  localparam int EMPTY_W  = $clog2(SEG_BYTES);
  localparam int BYTES_W  = $clog2(SEG_BYTES) + 1;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [7:0]       first;
  } tally_t;
endpackage

// File: rtl/slt_seg_bytes.sv
module slt_seg_bytes
  import slt_pkg::*;
(
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  output logic [BYTES_W-1:0] bytes
);
  always_comb begin
    if (eop) bytes = BYTES_W'(SEG_BYTES) - BYTES_W'(empty);
    else     bytes = BYTES_W'(SEG_BYTES);
  end
endmodule

// File: rtl/slt_chain.sv
module slt_chain
  import slt_pkg::*;
(
  input  logic [SEG_N-1:0]  vld,
  input  logic [SEG_N-1:0]  sop,
  input  logic [CHAN_W-1:0] chan  [SEG_N],
  input  logic [BYTES_W-1:0] bytes [SEG_N],
  input  logic [7:0]        top_byte [SEG_N],
  input  tally_t            rd_tally [SEG_N],
  output tally_t            run_tally [SEG_N],
  output logic [SEG_N-1:0]  last_of_chan
);
  tally_t prior [SEG_N];

  always_comb begin
    for (int m = 0; m < SEG_N; m++) begin
      prior[m] = rd_tally[m];
      for (int k = 0; k < m; k++) begin
        if (vld[k] && chan[k] == chan[m]) prior[m] = run_tally[k];
      end
      if (sop[m]) begin
        run_tally[m].len   = LEN_W'(bytes[m]);
        run_tally[m].first = top_byte[m];
      end else begin
        run_tally[m].len   = prior[m].len + LEN_W'(bytes[m]);
        run_tally[m].first = prior[m].first;
      end
    end
  end

  always_comb begin
    for (int m = 0; m < SEG_N; m++) begin
      last_of_chan[m] = vld[m];
      for (int k = m + 1; k < SEG_N; k++) begin
        if (vld[k] && chan[k] == chan[m]) last_of_chan[m] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/slt_tally_bank.sv
module slt_tally_bank
  import slt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] rd_chan  [SEG_N],
  output tally_t            rd_tally [SEG_N],
  input  logic [SEG_N-1:0]  wr_en,
  input  logic [CHAN_W-1:0] wr_chan  [SEG_N],
  input  tally_t            wr_tally [SEG_N]
);
  tally_t bank_q [CHAN_N];
  tally_t bank_d [CHAN_N];
  logic   bank_ce;

  always_comb begin
    for (int m = 0; m < SEG_N; m++) rd_tally[m] = bank_q[rd_chan[m]];
  end

  always_comb begin
    bank_ce = |wr_en;
    for (int c = 0; c < CHAN_N; c++) begin
      bank_d[c] = bank_q[c];
      for (int m = 0; m < SEG_N; m++) begin
        if (wr_en[m] && wr_chan[m] == CHAN_W'(c)) bank_d[c] = wr_tally[m];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < CHAN_N; c++) bank_q[c] <= '0;
    end else if (bank_ce) begin
      for (int c = 0; c < CHAN_N; c++) bank_q[c] <= bank_d[c];
    end
  end
endmodule

// File: rtl/seg_len_tally.sv
module seg_len_tally
  import slt_pkg::*;
#(
  parameter int NSEG = SEG_N,
  parameter int CW   = CHAN_W,
  parameter int EW   = EMPTY_W,
  parameter int DW   = SEG_W,
  parameter int LW   = LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEG-1:0]   in_vld,
  input  logic [NSEG-1:0]   in_sop,
  input  logic [NSEG-1:0]   in_eop,
  input  logic [NSEG-1:0]   in_err,
  input  logic [NSEG*CW-1:0] in_chan,
  input  logic [NSEG*EW-1:0] in_empty,
  input  logic [NSEG*DW-1:0] in_data,
  output logic [NSEG-1:0]   rec_vld,
  output logic [NSEG*CW-1:0] rec_chan,
  output logic [NSEG*LW-1:0] rec_len,
  output logic [NSEG-1:0]   rec_err,
  output logic [NSEG*8-1:0] rec_first
);
  logic rst_meta, rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  logic [CHAN_W-1:0]  seg_chan  [SEG_N];
  logic [BYTES_W-1:0] seg_bytes [SEG_N];
  logic [7:0]         seg_top   [SEG_N];
  tally_t             rd_tally  [SEG_N];
  tally_t             run_tally [SEG_N];
  logic [SEG_N-1:0]   last_of_chan;

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      assign seg_chan[g] = in_chan[g*CW +: CW];
      assign seg_top[g]  = in_data[g*DW + DW - 8 +: 8];
      slt_seg_bytes u_bytes (
        .eop   (in_eop[g]),
        .empty (in_empty[g*EW +: EW]),
        .bytes (seg_bytes[g])
      );
    end
  endgenerate

  slt_chain u_chain (
    .vld          (in_vld),
    .sop          (in_sop),
    .chan         (seg_chan),
    .bytes        (seg_bytes),
    .top_byte     (seg_top),
    .rd_tally     (rd_tally),
    .run_tally    (run_tally),
    .last_of_chan (last_of_chan)
  );

  slt_tally_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_chan  (seg_chan),
    .rd_tally (rd_tally),
    .wr_en    (last_of_chan),
    .wr_chan  (seg_chan),
    .wr_tally (run_tally)
  );

  // Completion record registers: next-state then register
  logic [NSEG-1:0]    rec_vld_d;
  logic [NSEG*CW-1:0] rec_chan_d;
  logic [NSEG*LW-1:0] rec_len_d;
  logic [NSEG-1:0]    rec_err_d;
  logic [NSEG*8-1:0]  rec_first_d;
  logic               rec_ce;

  always_comb begin
    rec_ce      = (|in_vld) | (|rec_vld);
    rec_vld_d   = in_vld & in_eop;
    rec_err_d   = in_err & in_vld & in_eop;
    rec_chan_d  = in_chan;
    for (int m = 0; m < NSEG; m++) begin
      rec_len_d[m*LW +: LW]  = run_tally[m].len;
      rec_first_d[m*8 +: 8]  = run_tally[m].first;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rec_vld   <= '0;
      rec_chan  <= '0;
      rec_len   <= '0;
      rec_err   <= '0;
      rec_first <= '0;
    end else if (rec_ce) begin
      rec_vld   <= rec_vld_d;
      rec_chan  <= rec_chan_d;
      rec_len   <= rec_len_d;
      rec_err   <= rec_err_d;
      rec_first <= rec_first_d;
    end
  end
endmodule

// File: rtl/seg_len_tally_check.sv
module seg_len_tally_check
  import slt_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rst_n_sync,
  input logic [SEG_N-1:0]      in_vld,
  input logic [SEG_N-1:0]      in_sop,
  input logic [SEG_N-1:0]      in_eop,
  input logic [SEG_N-1:0]      in_err,
  input logic [SEG_N*CHAN_W-1:0]  in_chan,
  input logic [SEG_N*EMPTY_W-1:0] in_empty,
  input logic [SEG_N*SEG_W-1:0]   in_data,
  input logic [SEG_N-1:0]      rec_vld,
  input logic [SEG_N*CHAN_W-1:0]  rec_chan,
  input logic [SEG_N*LEN_W-1:0]   rec_len,
  input logic [SEG_N-1:0]      rec_err,
  input logic [SEG_N*8-1:0]    rec_first
);
  always @(posedge clk) begin
    if (!rst_n) assert_quiet_in_reset_R10: assert (rec_vld == '0);
  end

  genvar g;
  generate
    for (g = 0; g < SEG_N; g++) begin : g_chk
      assert_rec_follows_end_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
        rec_vld[g] == $past(in_vld[g] & in_eop[g]));
      assert_rec_chan_R11: assert property (@(posedge clk) disable iff (!rst_n_sync)
        rec_vld[g] |-> rec_chan[g*CHAN_W +: CHAN_W] == $past(in_chan[g*CHAN_W +: CHAN_W]));
      assert_rec_err_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
        rec_vld[g] |-> rec_err[g] == $past(in_err[g]));
      assert_single_len_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (rec_vld[g] && $past(in_sop[g])) |->
        rec_len[g*LEN_W +: LEN_W] == LEN_W'(SEG_BYTES) - LEN_W'($past(in_empty[g*EMPTY_W +: EMPTY_W])));
      assert_single_first_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (rec_vld[g] && $past(in_sop[g])) |->
        rec_first[g*8 +: 8] == $past(in_data[g*SEG_W + SEG_W - 8 +: 8]));
    end
  endgenerate
endmodule

bind seg_len_tally seg_len_tally_check u_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_n_sync (rst_n_sync),
  .in_vld     (in_vld),
  .in_sop     (in_sop),
  .in_eop     (in_eop),
  .in_err     (in_err),
  .in_chan    (in_chan),
  .in_empty   (in_empty),
  .in_data    (in_data),
  .rec_vld    (rec_vld),
  .rec_chan   (rec_chan),
  .rec_len    (rec_len),
  .rec_err    (rec_err),
  .rec_first  (rec_first)
);

// File: tb/sim_seg_len_tally.sv
`timescale 1ns/1ps
module sim_seg_len_tally;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]   in_vld, in_sop, in_eop, in_err;
  logic [15:0]  in_chan, in_empty;
  logic [511:0] in_data;
  logic [3:0]   rec_vld, rec_err;
  logic [15:0]  rec_chan;
  logic [63:0]  rec_len;
  logic [31:0]  rec_first;

  seg_len_tally u0 (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
    .in_chan(in_chan), .in_empty(in_empty), .in_data(in_data),
    .rec_vld(rec_vld), .rec_chan(rec_chan), .rec_len(rec_len),
    .rec_err(rec_err), .rec_first(rec_first)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] m_len [16];
  logic [7:0]  m_first [16];
  logic [3:0]  x_vld, x_err;
  logic [3:0]  x_chan [4];
  logic [15:0] x_len [4];
  logic [7:0]  x_first [4];

  function automatic void model_reset();
    for (int c = 0; c < 16; c++) begin m_len[c] = '0; m_first[c] = '0; end
  endfunction

  function automatic void model_step();
    for (int m = 0; m < 4; m++) begin
      logic [3:0] ch;
      logic [15:0] add;
      ch = in_chan[m*4 +: 4];
      x_vld[m] = in_vld[m] & in_eop[m];
      x_err[m] = in_err[m];
      x_chan[m] = ch;
      if (in_vld[m]) begin
        add = in_eop[m] ? 16'd16 - 16'(in_empty[m*4 +: 4]) : 16'd16;
        if (in_sop[m]) begin
          m_len[ch] = add;
          m_first[ch] = in_data[m*128 + 120 +: 8];
        end else begin
          m_len[ch] = m_len[ch] + add;
        end
        x_len[m] = m_len[ch];
        x_first[m] = m_first[ch];
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int m = 0; m < 4; m++) begin
      check(rec_vld[m] == x_vld[m], "R1", "rec_vld", rec_vld[m], x_vld[m]);
      if (x_vld[m] && rec_vld[m]) begin
        check(rec_len[m*16 +: 16] == x_len[m], "R2/R3/R4/R5", "rec_len", rec_len[m*16 +: 16], x_len[m]);
        check(rec_chan[m*4 +: 4] == x_chan[m], "R11", "rec_chan", rec_chan[m*4 +: 4], x_chan[m]);
        check(rec_err[m] == x_err[m], "R7", "rec_err", rec_err[m], x_err[m]);
        check(rec_first[m*8 +: 8] == x_first[m], "R8/R6", "rec_first", rec_first[m*8 +: 8], x_first[m]);
      end
    end
  endtask

  task automatic clear_in();
    in_vld = '0; in_sop = '0; in_eop = '0; in_err = '0;
    in_chan = '0; in_empty = '0;
    in_data = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
               $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic put(input int m, input bit v, input bit s, input bit e, input bit er,
                     input logic [3:0] ch, input logic [3:0] em, input logic [7:0] b);
    in_vld[m] = v; in_sop[m] = s; in_eop[m] = e; in_err[m] = er;
    in_chan[m*4 +: 4] = ch; in_empty[m*4 +: 4] = em;
    in_data[m*128 + 120 +: 8] = b;
  endtask

  // inputs already applied at a falling edge; result visible at the next falling edge
  task automatic step();
    model_step();
    @(negedge clk);
    compare();
    clear_in();
  endtask

  task automatic expect_len(input int m, input logic [15:0] v, input string tag);
    check(rec_vld[m] && rec_len[m*16 +: 16] == v, tag, "directed length", rec_len[m*16 +: 16], v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    clear_in();
    model_reset();
    repeat (3) @(negedge clk);
    check(rec_vld == '0, "R10", "rec_vld in reset", rec_vld, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rec_vld == '0, "R10", "rec_vld after reset", rec_vld, 0);
    clear_in();

    // R10: no start after reset, length counts only this segment
    put(0, 1, 0, 1, 0, 4'd5, 4'd0, 8'hA1); step(); expect_len(0, 16'd16, "R10");
    // R3: one valid byte
    put(0, 1, 1, 1, 0, 4'd6, 4'd15, 8'h3C); step(); expect_len(0, 16'd1, "R3");
    check(rec_first[7:0] == 8'h3C, "R8", "first byte", rec_first[7:0], 8'h3C);
    // R5/R2: one packet over four segments, empty 3 -> 61
    put(0, 1, 1, 0, 0, 4'd2, 4'd0, 8'h11);
    put(1, 1, 0, 0, 0, 4'd2, 4'd0, 8'h22);
    put(2, 1, 0, 0, 0, 4'd2, 4'd0, 8'h33);
    put(3, 1, 0, 1, 0, 4'd2, 4'd3, 8'h44);
    step(); expect_len(3, 16'd61, "R5");
    check(rec_vld == 4'b1000, "R1", "only end slot", rec_vld, 4'b1000);
    // R5/R1: four packets on one channel in one cycle
    put(0, 1, 1, 1, 0, 4'd7, 4'd0, 8'h01);
    put(1, 1, 1, 1, 1, 4'd7, 4'd4, 8'h02);
    put(2, 1, 1, 1, 0, 4'd7, 4'd8, 8'h03);
    put(3, 1, 1, 1, 0, 4'd7, 4'd12, 8'h04);
    step(); expect_len(1, 16'd12, "R5"); expect_len(3, 16'd4, "R5");
    check(rec_err == 4'b0010, "R7", "error slot", rec_err, 4'b0010);
    // R9: disabled end segment on ch3 has no effect
    put(0, 1, 1, 0, 0, 4'd3, 4'd0, 8'h55); step();
    put(0, 1, 1, 0, 0, 4'd9, 4'd0, 8'h66);
    put(1, 0, 1, 1, 1, 4'd3, 4'd7, 8'h77); step();
    check(rec_vld == 4'b0000, "R9", "no record from disabled", rec_vld, 0);
    put(0, 1, 0, 1, 0, 4'd3, 4'd0, 8'h88); step(); expect_len(0, 16'd32, "R9");
    check(rec_first[7:0] == 8'h55, "R9", "first byte kept", rec_first[7:0], 8'h55);
    // R6/R4: interleaved channels, restart discards old length
    put(0, 1, 1, 0, 0, 4'd1, 4'd0, 8'hB1);
    put(1, 1, 1, 0, 0, 4'd4, 4'd0, 8'hB4); step();
    put(0, 1, 1, 0, 0, 4'd1, 4'd0, 8'hC1);
    put(1, 1, 0, 1, 0, 4'd4, 4'd2, 8'h00);
    put(2, 1, 0, 1, 0, 4'd1, 4'd0, 8'h00); step();
    expect_len(1, 16'd30, "R6"); expect_len(2, 16'd32, "R4");
    check(rec_first[23:16] == 8'hC1, "R4", "restart first byte", rec_first[23:16], 8'hC1);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int n;
      n = $urandom_range(0, 4);
      for (int m = 0; m < 4; m++) begin
        logic [3:0] ch;
        ch = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 2));
        put(m, m < n, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
            $urandom_range(0, 4) == 0, ch, 4'($urandom_range(0, 15)), 8'($urandom));
      end
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule